// File: doc/BRIEF.md
# Suspend Modulation Duty Generator

This block throttles a processor core by driving an active-low suspend line. While modulation is on, the line alternates between two phases. In the free-running phase it is high and the core runs. In the suspend phase it is low and the core idles. Each phase lasts an 8-bit number of base ticks. A prescaler derives the base tick from the system clock, nominally 32 µs. The core therefore keeps a fraction of full throughput equal to run / (run + suspend).

Software programs the phase lengths and an enable bit through a small register file. The register file uses a plain write strobe with an address, and reads are combinational. Two event inputs, one for interrupts and one for video activity, can each open a speedup window. While a window is open, the core runs at full speed. Each window length is programmed in millisecond units. The millisecond tick comes from the same prescaler chain.

Top module: `susp_mod_gen`

## Requirements
- R1: After reset, every register reads 0 and `susp_no_o` is 1.
- R2: The register map is as follows: address 0 is the run count, 1 is the suspend count, 2 is control (bit 0 enables modulation), 3 is speedup enable (bit 0 is interrupt, bit 1 is video), 4 is the interrupt window in ms, and 5 is the video window in ms. Each register reads back what was written to it. Addresses 6 and 7 read 0, and writes to them are ignored.
- R3: While control bit 0 is 0, `susp_no_o` stays 1, whatever the other control bits hold.
- R4: With both counts nonzero, the output alternates between a high phase of RUN ticks and a low phase of SUSP ticks. Each phase lasts more than (N−1)·T and at most N·T+1 clock cycles, where T is the number of clocks per tick.
- R5: A suspend count of 0 keeps `susp_no_o` at 1 for any run count.
- R6: A run count of 0 with a nonzero suspend count holds `susp_no_o` at 0 continuously while modulation is enabled.
- R7: Counts written during a period take effect only when a new period begins. A low phase in progress completes with its old length.
- R8: A pulse on `irq_evt_i` with speedup enable bit 0 set drives `susp_no_o` to 1 for the programmed number of ms. The window lasts more than (W−1)·M and at most W·M+1 cycles, where M is the number of clocks per ms. After the window, modulation restarts with a fresh period. The event has no effect when its enable bit is 0 or when its window value is 0.
- R9: `vid_evt_i` behaves in the same way using enable bit 1 and the video window register. It is independent of the interrupt enable bit.
- R10: An event that arrives inside an open window restarts that window from its full length.
- R11: The two windows run independently. The output is held at 1 while either window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address for writes and reads |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` |
| irq_evt_i | input | 1 | Interrupt activity pulse |
| vid_evt_i | input | 1 | Video activity pulse |
| susp_no_o | output | 1 | Active-low suspend request to the core |

## Verification
The interrupt window and the video window can both open on the same clock edge. The bench provokes this by pulsing both event inputs in one cycle, with the video window twice as long as the interrupt window. It judges the result by the length of the high stretch on `susp_no_o`, which must match the longer window and not the shorter one. A retrigger is also provoked: a second interrupt pulse arrives partway through an open window. The remaining high time must then be a full window measured from the second pulse.

// File: rtl/susp_mod_pkg.sv
package susp_mod_pkg;

  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_SUSP = 1'b1
  } phase_e;

  localparam int REG_COUNT = 6;

  localparam int ADDR_RUN   = 0;
  localparam int ADDR_SUSP  = 1;
  localparam int ADDR_CTRL  = 2;
  localparam int ADDR_SPEN  = 3;
  localparam int ADDR_IRQW  = 4;
  localparam int ADDR_VIDW  = 5;

  localparam int CTRL_EN_BIT  = 0;
  localparam int SPEN_IRQ_BIT = 0;
  localparam int SPEN_VID_BIT = 1;

  localparam int SRC_COUNT = 2;

endpackage

// File: rtl/susp_prescaler.sv
module susp_prescaler #(
  parameter int CLKS_PER_TICK = 1056,
  parameter int TICKS_PER_MS  = 31
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic ms_tick_o
);

  localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam int MW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PW-1:0] P_MAX = PW'(CLKS_PER_TICK - 1);
  localparam logic [MW-1:0] M_MAX = MW'(TICKS_PER_MS - 1);

  logic [PW-1:0] presc_q;
  logic [MW-1:0] ms_q;

  assign tick_o    = (presc_q == P_MAX);
  assign ms_tick_o = tick_o && (ms_q == M_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
    end else if (tick_o) begin
      presc_q <= '0;
    end else begin
      presc_q <= presc_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_q <= '0;
    end else if (ms_tick_o) begin
      ms_q <= '0;
    end else if (tick_o) begin
      ms_q <= ms_q + 1'b1;
    end
  end

  generate
    if (CLKS_PER_TICK > 1) begin : g_spacing
      a_r4_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/susp_regfile.sv
module susp_regfile
  import susp_mod_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] run_cnt_o,
  output logic [DW-1:0] susp_cnt_o,
  output logic          mod_en_o,
  output logic          irq_sp_en_o,
  output logic          vid_sp_en_o,
  output logic [DW-1:0] irq_win_o,
  output logic [DW-1:0] vid_win_o
);

  logic [DW-1:0] regs_q [REG_COUNT];

  generate
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          regs_q[g] <= '0;
        end else if (wr_en_i && (addr_i == AW'(g))) begin
          regs_q[g] <= wr_data_i;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (addr_i == AW'(i)) rd_data_o = regs_q[i];
    end
  end

  assign run_cnt_o   = regs_q[ADDR_RUN];
  assign susp_cnt_o  = regs_q[ADDR_SUSP];
  assign mod_en_o    = regs_q[ADDR_CTRL][CTRL_EN_BIT];
  assign irq_sp_en_o = regs_q[ADDR_SPEN][SPEN_IRQ_BIT];
  assign vid_sp_en_o = regs_q[ADDR_SPEN][SPEN_VID_BIT];
  assign irq_win_o   = regs_q[ADDR_IRQW];
  assign vid_win_o   = regs_q[ADDR_VIDW];

  a_r2_susp_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(ADDR_SUSP)) |=> susp_cnt_o == $past(wr_data_i));

  a_r2_run_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(ADDR_RUN)) |=> run_cnt_o == $past(wr_data_i));

endmodule

// File: rtl/susp_speedup_timer.sv
module susp_speedup_timer #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ms_tick_i,
  input  logic          evt_i,
  input  logic          en_i,
  input  logic [DW-1:0] win_i,
  output logic          active_o
);

  logic [DW-1:0] cnt_q;
  logic          load;

  assign load     = evt_i && en_i;
  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= win_i;  // retrigger restarts the window
    end else if (ms_tick_i && active_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r10_retrigger_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> cnt_q == $past(win_i));

  a_r8_window_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !ms_tick_i && !load) |=> $stable(cnt_q));

  a_r8_disabled_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && cnt_q == '0) |=> cnt_q == '0);

endmodule

// File: rtl/susp_duty_seq.sv
module susp_duty_seq
  import susp_mod_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_en_i,
  input  logic [DW-1:0] run_val_i,
  input  logic [DW-1:0] susp_val_i,
  output logic          susp_no_o
);

  phase_e        phase_q, phase_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] lat_run_q, lat_run_d;
  logic [DW-1:0] lat_susp_q, lat_susp_d;
  logic          live_q, live_d;
  logic          period_end;

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    lat_run_d  = lat_run_q;
    lat_susp_d = lat_susp_q;
    live_d     = live_q;
    period_end = 1'b0;
    if (!run_en_i) begin
      live_d  = 1'b0;
      phase_d = PH_RUN;
      cnt_d   = '0;
    end else begin
      if (!live_q) begin
        period_end = 1'b1;
      end else if (phase_q == PH_RUN) begin
        period_end = (cnt_q == lat_run_q) && (lat_susp_q == '0);
      end else begin
        period_end = (cnt_q == lat_susp_q);
      end

      if (period_end) begin
        // new period: latch counts, skip an empty run phase
        live_d     = 1'b1;
        lat_run_d  = run_val_i;
        lat_susp_d = susp_val_i;
        cnt_d      = '0;
        phase_d    = (run_val_i == '0 && susp_val_i != '0) ? PH_SUSP : PH_RUN;
      end else if (phase_q == PH_RUN && cnt_q == lat_run_q) begin
        phase_d = PH_SUSP;
        cnt_d   = '0;
      end else if (tick_i) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_RUN;
      cnt_q      <= '0;
      lat_run_q  <= '0;
      lat_susp_q <= '0;
      live_q     <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      cnt_q      <= cnt_d;
      lat_run_q  <= lat_run_d;
      lat_susp_q <= lat_susp_d;
      live_q     <= live_d;
    end
  end

  assign susp_no_o = !(run_en_i && live_q && phase_q == PH_SUSP);

  a_r4_susp_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && phase_q == PH_SUSP) |-> cnt_q <= lat_susp_q);

  a_r5_zero_susp_stays_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && lat_susp_q == '0) |-> phase_q == PH_RUN);

  a_r6_zero_run_stays_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && lat_run_q == '0 && lat_susp_q != '0) |-> phase_q == PH_SUSP);

  a_r7_latch_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_i && live_q && phase_q == PH_SUSP && cnt_q != lat_susp_q)
      |=> ($stable(lat_run_q) && $stable(lat_susp_q)));

endmodule

// File: rtl/susp_mod_gen.sv
module susp_mod_gen
  import susp_mod_pkg::*;
#(
  parameter int CLKS_PER_TICK = 1056,
  parameter int TICKS_PER_MS  = 31,
  parameter int AW            = 3,
  parameter int DW            = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          irq_evt_i,
  input  logic          vid_evt_i,
  output logic          susp_no_o
);

  logic          tick, ms_tick;
  logic [DW-1:0] run_cnt, susp_cnt, irq_win, vid_win;
  logic          mod_en, irq_sp_en, vid_sp_en;
  logic          speedup_any;

  logic [SRC_COUNT-1:0] src_evt, src_en, src_act;
  logic [DW-1:0]        src_win [SRC_COUNT];

  susp_prescaler #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .TICKS_PER_MS (TICKS_PER_MS)
  ) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_o   (tick),
    .ms_tick_o(ms_tick)
  );

  susp_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .run_cnt_o  (run_cnt),
    .susp_cnt_o (susp_cnt),
    .mod_en_o   (mod_en),
    .irq_sp_en_o(irq_sp_en),
    .vid_sp_en_o(vid_sp_en),
    .irq_win_o  (irq_win),
    .vid_win_o  (vid_win)
  );

  assign src_evt    = {vid_evt_i, irq_evt_i};
  assign src_en     = {vid_sp_en, irq_sp_en};
  assign src_win[0] = irq_win;
  assign src_win[1] = vid_win;

  generate
    for (genvar s = 0; s < SRC_COUNT; s++) begin : g_speedup
      susp_speedup_timer #(.DW(DW)) u_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ms_tick_i(ms_tick),
        .evt_i    (src_evt[s]),
        .en_i     (src_en[s]),
        .win_i    (src_win[s]),
        .active_o (src_act[s])
      );
    end
  endgenerate

  assign speedup_any = |src_act;

  susp_duty_seq #(.DW(DW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .run_en_i  (mod_en && !speedup_any),
    .run_val_i (run_cnt),
    .susp_val_i(susp_cnt),
    .susp_no_o (susp_no_o)
  );

  a_r3_disabled_full_speed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en |-> susp_no_o);

  a_r11_window_full_speed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speedup_any |-> susp_no_o);

endmodule

// File: tb/susp_mod_gen_tb.sv
module susp_mod_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int P   = 4;
  localparam int TPM = 8;
  localparam int M   = P * TPM;
  localparam int RUN_LIMIT = 6000;

  // {run, susp} pairs for the R4 walk
  localparam int NVEC = 5;
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd3,  8'd5},
    {8'd1,  8'd1},
    {8'd10, 8'd2},
    {8'd2,  8'd40},
    {8'd7,  8'd7}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       irq_evt_i = 1'b0;
  logic       vid_evt_i = 1'b0;
  logic       susp_no_o;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  susp_mod_gen #(
    .CLKS_PER_TICK(P),
    .TICKS_PER_MS (TPM),
    .AW(3),
    .DW(8)
  ) dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .irq_evt_i(irq_evt_i),
    .vid_evt_i(vid_evt_i),
    .susp_no_o(susp_no_o)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    addr_i = 3'(a); wr_data_i = 8'(d); wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk_i);
    addr_i = 3'(a);
    #1 d = int'(rd_data_o);
  endtask

  // returns at a negedge where susp_no_o == lvl
  task automatic wait_lvl(input logic lvl);
    int n = 0;
    while (susp_no_o !== lvl && n < RUN_LIMIT) begin
      @(negedge clk_i); n++;
    end
  endtask

  task automatic run_len(input logic lvl, output int len);
    len = 0;
    while (susp_no_o === lvl && len < RUN_LIMIT) begin
      len++; @(negedge clk_i);
    end
  endtask

  task automatic hold_cnt(input logic lvl, input int cycles, output int bad);
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (susp_no_o !== lvl) bad++;
    end
  endtask

  task automatic pulse(input logic irq, input logic vid);
    @(negedge clk_i);
    irq_evt_i = irq; vid_evt_i = vid;
    @(negedge clk_i);
    irq_evt_i = 1'b0; vid_evt_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int d, len, bad, rn, sp;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk_eq("R1 susp_no", int'(susp_no_o), 1);
    for (int a = 0; a < 6; a++) begin
      rd(a, d); chk_eq("R1 reg reset", d, 0);
    end

    // R2 map and unmapped addresses
    for (int a = 0; a < 8; a++) wr(a, 8'h30 + a * 8'h11);
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk_eq("R2 readback", d, (a < 6) ? ((8'h30 + a * 8'h11) & 8'hff) : 0);
    end
    wr(3, 0); wr(4, 0); wr(5, 0);

    // R3 enable bit 0 only
    wr(2, 0); wr(0, 2); wr(1, 5); wr(2, 8'hFE);
    hold_cnt(1'b1, 200, bad); chk_eq("R3 other bits set, bit0 clear", bad, 0);

    // R4 duty walk
    for (int v = 0; v < NVEC; v++) begin
      rn = int'(VEC[v][15:8]); sp = int'(VEC[v][7:0]);
      wr(2, 0); wr(0, rn); wr(1, sp); wr(2, 1);
      wait_lvl(1'b0); wait_lvl(1'b1);
      run_len(1'b1, len); chk_rng("R4 run phase", len, (rn-1)*P + 1, rn*P + 1);
      run_len(1'b0, len); chk_rng("R4 susp phase", len, (sp-1)*P + 1, sp*P + 1);
    end

    // R5 zero suspend count
    wr(2, 0); wr(0, 3); wr(1, 0); wr(2, 1);
    hold_cnt(1'b1, 300, bad); chk_eq("R5 never asserted", bad, 0);

    // R6 zero run count
    wr(2, 0); wr(0, 0); wr(1, 9); wr(2, 1);
    repeat (3) @(negedge clk_i);
    hold_cnt(1'b0, 300, bad); chk_eq("R6 continuous suspend", bad, 0);

    // R7 mid-period update
    wr(2, 0); wr(0, 2); wr(1, 20); wr(2, 1);
    wait_lvl(1'b1); wait_lvl(1'b0);
    wr(1, 3);
    run_len(1'b0, len); len += 2;
    chk_rng("R7 old susp length kept", len, 19*P + 1, 20*P + 1);
    run_len(1'b1, len);
    run_len(1'b0, len); chk_rng("R7 new susp length", len, 2*P + 1, 3*P + 1);

    // R8 interrupt window on continuous suspend
    wr(2, 0); wr(0, 0); wr(1, 9); wr(4, 5); wr(3, 0); wr(2, 1);
    wait_lvl(1'b0);
    pulse(1'b1, 1'b0);
    hold_cnt(1'b0, 100, bad); chk_eq("R8 disabled event ignored", bad, 0);
    wr(3, 1);
    pulse(1'b1, 1'b0);
    run_len(1'b1, len); chk_rng("R8 irq window", len, 4*M + 1, 5*M + 1);
    hold_cnt(1'b0, 20, bad); chk_eq("R8 resumes suspend", bad, 0);
    wr(4, 0);
    pulse(1'b1, 1'b0);
    hold_cnt(1'b0, 100, bad); chk_eq("R8 zero window ignored", bad, 0);

    // R9 video window, independent of irq enable
    wr(5, 3); wr(4, 5); wr(3, 2);
    pulse(1'b1, 1'b0);
    hold_cnt(1'b0, 100, bad); chk_eq("R9 irq off while video on", bad, 0);
    pulse(1'b0, 1'b1);
    run_len(1'b1, len); chk_rng("R9 video window", len, 2*M + 1, 3*M + 1);

    // R10 retrigger inside window
    wr(4, 3); wr(3, 1);
    wait_lvl(1'b0);
    pulse(1'b1, 1'b0);
    hold_cnt(1'b1, 40, bad); chk_eq("R10 window open", bad, 0);
    pulse(1'b1, 1'b0);
    run_len(1'b1, len); chk_rng("R10 restarted window", len, 2*M, 3*M + 1);

    // R11 both events in one cycle
    wr(4, 2); wr(5, 4); wr(3, 3);
    wait_lvl(1'b0);
    pulse(1'b1, 1'b1);
    run_len(1'b1, len); chk_rng("R11 longer window wins", len, 3*M + 1, 4*M + 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule